// File: doc/BRIEF.md
# Skew Tent Map Step Engine

This block advances a discrete skew tent chaotic map by one iteration on W-bit unsigned words (W = 32 by default). A caller presents the present state word and the breakpoint parameter together with a one-cycle start strobe. The engine compares the state with the breakpoint and picks one of three branches. Two of them divide a 2^W-scaled numerator by a branch-dependent divisor and round the quotient upward. The third returns the all-ones saturation value without dividing.

The scaled quotient comes from a restoring divider that resolves one quotient bit per clock. A dividing step therefore finishes W+1 cycles after it is accepted. A saturating step finishes after one cycle. Both operands are captured on the accepted start. A one-cycle done pulse announces each result, and the result then stays on the output until the next step completes. The engine is meant to sit inside a keystream generator, where it is called once for each new map sample.

Top module: `skew_tent_step`

## Requirements
- R1: When 0 < X < P, the result is ceil(2^W · X / P).
- R2: When X equals P, the result is 2^W − 1 (all ones).
- R3: When X is zero, the result is 2^W − 1 (all ones), the same as R2.
- R4: When X > P, the result is ceil(2^W · (2^W − X) / (2^W − P)).
- R5: The rounding is a true ceiling. An exact division returns the quotient unchanged, and any nonzero remainder adds one.
- R6: The done pulse appears exactly W+1 cycles after the accepting clock edge for the dividing branches (R1, R4), and exactly 1 cycle after it for the saturating branches (R2, R3).
- R7: done is high for a single cycle per step. The result is held unchanged on the output while done is low.
- R8: A start raised while a step is in flight is ignored. It produces no second done pulse and does not alter the result of the step in flight.
- R9: X and P are sampled on the accepting edge. Changing them afterwards does not affect the result.
- R10: After reset, done is 0, the result output is 0 and the engine accepts a start at once.
- R11: Every completed result is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request one map iteration; taken only when idle |
| x_in | input | W | Present map state X |
| p1 | input | W | Breakpoint parameter P, expected in 1..2^W−1 |
| x_out | output | W | Next map state, held between completions |
| done | output | 1 | One-cycle pulse marking a new x_out |

## Verification
A dividing step is due W+1 = 33 cycles after the edge that takes start, and a saturating step is due 1 cycle after that edge. The bench drives start on a falling edge and then counts falling edges until done is seen. It compares that count with the exact figure for the branch, so a result that arrives early or late fails even if its value is right. The result value is sampled on the same falling edge as the done pulse. During the ignored-start and late-operand scenarios, the bench keeps watching for a cycle window longer than a full division. This catches any stray second done pulse and any change of the held output.

// File: rtl/skew_tent_pkg.sv
package skew_tent_pkg;

    // Which branch of the map a state word falls into.
    typedef enum logic [1:0] {
        BR_SAT  = 2'd0,   // X == P or X == 0: saturate to all ones
        BR_LOW  = 2'd1,   // 0 < X < P
        BR_HIGH = 2'd2    // X > P
    } ste_branch_e;

    // Width of a counter able to hold the value n.
    function automatic int unsigned ste_cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/ste_branch_sel.sv
module ste_branch_sel
    import skew_tent_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] p,
    output ste_branch_e  br,
    output logic [W:0]   num_hi,
    output logic [W:0]   den
);
    localparam logic [W:0] FULL = {1'b1, {W{1'b0}}};

    logic [W:0] x_ext;
    logic [W:0] p_ext;

    assign x_ext = {1'b0, x};
    assign p_ext = {1'b0, p};

    // The numerator is num_hi * 2^W; only its upper half is carried.
    always_comb begin
        br     = BR_SAT;
        num_hi = '0;
        den    = FULL;
        if (x == '0 || x == p) begin
            br = BR_SAT;
        end else if (x < p) begin
            br     = BR_LOW;
            num_hi = x_ext;
            den    = p_ext;
        end else begin
            br     = BR_HIGH;
            num_hi = FULL - x_ext;
            den    = FULL - p_ext;
        end
    end
endmodule

// File: rtl/ste_restoring_div.sv
module ste_restoring_div
    import skew_tent_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W:0]   num_hi,
    input  logic [W:0]   den,
    output logic [W-1:0] q,
    output logic         rem_nz,
    output logic         valid
);
    localparam int unsigned CW   = ste_cnt_width(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [W+1:0]  rem;
    logic [W:0]    den_q;
    logic [CW-1:0] cnt;
    logic          run;
    logic [W+1:0]  trial;
    logic [W+1:0]  den_ext;
    logic          fits;

    assign trial   = {rem[W:0], 1'b0};
    assign den_ext = {1'b0, den_q};
    assign fits    = (trial >= den_ext);
    assign rem_nz  = (rem != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rem   <= '0;
            den_q <= '0;
            cnt   <= '0;
            run   <= 1'b0;
            q     <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (go && !run) begin
                rem   <= {1'b0, num_hi};
                den_q <= den;
                cnt   <= '0;
                q     <= '0;
                run   <= 1'b1;
            end else if (run) begin
                if (fits) begin
                    rem <= trial - den_ext;
                    q   <= {q[W-2:0], 1'b1};
                end else begin
                    rem <= trial;
                    q   <= {q[W-2:0], 1'b0};
                end
                cnt <= cnt + 1'b1;
                if (cnt == LAST) begin
                    run   <= 1'b0;
                    valid <= 1'b1;
                end
            end
        end
    end

    // Partial remainder always stays below the divisor during the run (R5).
    assert_rem_below_div_R5: assert property (@(posedge clk) disable iff (rst)
        run |-> (rem < den_ext));

    // Step counter never passes the last quotient bit (R6).
    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= LAST));

    // A kick while idle always starts a run (R6).
    assert_go_starts_R6: assert property (@(posedge clk) disable iff (rst)
        (go && !run) |=> run);
endmodule

// File: rtl/ste_ceil_round.sv
module ste_ceil_round #(
    parameter int unsigned W = 32
) (
    input  logic         en,
    input  logic [W-1:0] q,
    input  logic         rem_nz,
    output logic [W-1:0] y
);
    assign y = q + {{(W-1){1'b0}}, rem_nz};

    // Rounding up must never wrap past all ones (R5).
    always_comb begin
        if (en && rem_nz) begin
            assert_no_overflow_R5: assert (q != '1);
        end
    end
endmodule

// File: rtl/skew_tent_step.sv
module skew_tent_step
    import skew_tent_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] p1,
    output logic [W-1:0] x_out,
    output logic         done
);
    localparam int unsigned LW = ste_cnt_width(W + 2);

    ste_branch_e  br;
    logic [W:0]   num_hi;
    logic [W:0]   den;
    logic         busy;
    logic         sat_pend;
    logic         accept;
    logic         div_go;
    logic [W-1:0] div_q;
    logic         div_nz;
    logic         div_valid;
    logic [W-1:0] rounded;
    logic         finish;
    logic [W-1:0] result;

    ste_branch_sel #(.W(W)) u_sel (
        .x      (x_in),
        .p      (p1),
        .br     (br),
        .num_hi (num_hi),
        .den    (den)
    );

    assign accept = start && !busy;
    assign div_go = accept && (br != BR_SAT);

    ste_restoring_div #(.W(W)) u_div (
        .clk    (clk),
        .rst    (rst),
        .go     (div_go),
        .num_hi (num_hi),
        .den    (den),
        .q      (div_q),
        .rem_nz (div_nz),
        .valid  (div_valid)
    );

    ste_ceil_round #(.W(W)) u_round (
        .en     (div_valid),
        .q      (div_q),
        .rem_nz (div_nz),
        .y      (rounded)
    );

    assign finish = sat_pend || div_valid;
    assign result = sat_pend ? {W{1'b1}} : rounded;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            sat_pend <= 1'b0;
            done     <= 1'b0;
            x_out    <= '0;
        end else begin
            done     <= finish;
            sat_pend <= accept && (br == BR_SAT);
            if (finish) begin
                x_out <= result;
            end
            if (accept) begin
                busy <= 1'b1;
            end else if (finish) begin
                busy <= 1'b0;
            end
        end
    end

    // Checker state: cycles since acceptance, and a post-reset qualifier.
    logic [LW-1:0] lat_cnt;
    logic          past_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_cnt <= '0;
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            if (accept) begin
                lat_cnt <= '0;
            end else if (busy) begin
                lat_cnt <= lat_cnt + 1'b1;
            end
        end
    end

    // Divider result lands exactly W cycles after acceptance (R6).
    assert_div_latency_R6: assert property (@(posedge clk) disable iff (rst)
        div_valid |-> (lat_cnt == LW'(W)));

    // done never lasts more than one cycle (R7).
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // Output held between completions (R7).
    assert_hold_out_R7: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !done) |-> $stable(x_out));

    // An in-flight step cannot be dropped by a new start (R8).
    assert_busy_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && !finish) |=> busy);

    // A completed result is never zero (R11).
    assert_nonzero_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> (x_out != '0));
endmodule

// File: tb/skew_tent_step_bench.sv
module skew_tent_step_bench;
    localparam int W       = 32;
    localparam int DIV_LAT = W + 1;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [W-1:0] x_in;
    logic [W-1:0] p1;
    logic [W-1:0] x_out;
    logic         done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    skew_tent_step #(.W(W)) u_skew_tent_step (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .x_in  (x_in),
        .p1    (p1),
        .x_out (x_out),
        .done  (done)
    );

    function automatic logic [W-1:0] model(input logic [W-1:0] x, input logic [W-1:0] p);
        logic [2*W+1:0] num;
        logic [2*W+1:0] dv;
        logic [2*W+1:0] qq;
        logic [2*W+1:0] rr;
        if (x == 0 || x == p) return '1;
        if (x < p) begin
            num = {{(W+2){1'b0}}, x} << W;
            dv  = {{(W+2){1'b0}}, p};
        end else begin
            num = ((66'd1 << W) - {{(W+2){1'b0}}, x}) << W;
            dv  = (66'd1 << W) - {{(W+2){1'b0}}, p};
        end
        qq = num / dv;
        rr = num % dv;
        if (rr != 0) qq = qq + 1;
        return qq[W-1:0];
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Issue one step; optionally scramble operands after acceptance.
    task automatic run_step(input logic [W-1:0] x, input logic [W-1:0] p,
                            input string req, input bit scramble);
        int lat;
        int exp_lat;
        @(negedge clk);
        x_in  = x;
        p1    = p;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (scramble) begin
            x_in = ~x;
            p1   = p ^ 32'h5A5A_0F0F;
        end
        lat = 0;
        for (int i = 1; i <= 100; i++) begin
            if (lat == 0 && done) lat = i - 1;
            if (lat != 0) break;
            @(negedge clk);
        end
        exp_lat = (x == 0 || x == p) ? 1 : DIV_LAT;
        check({req, " latency R6"}, lat, exp_lat);
        check({req, " value"}, x_out, model(x, p));
        check("R11 nonzero", (x_out != 0), 1);
    endtask

    task automatic t_reset;
        check("R10 done after reset", done, 0);
        check("R10 x_out after reset", x_out, 0);
    endtask

    task automatic t_lower;
        run_step(32'd1, 32'd3, "R1 small", 0);
        run_step(32'h1234_5678, 32'h9ABC_DEF0, "R1 mid", 0);
        run_step(32'hFFFF_FFFD, 32'hFFFF_FFFF, "R1 top", 0);
        run_step(32'h7FFF_FFFF, 32'h8000_0000, "R5 exact low", 0);
        check("R5 exact low literal", x_out, 32'hFFFF_FFFE);
    endtask

    task automatic t_upper;
        run_step(32'hC000_0000, 32'h8000_0000, "R5 exact high", 0);
        check("R5 exact high literal", x_out, 32'h8000_0000);
        run_step(32'hFFFF_FFFF, 32'd1, "R4 edge", 0);
        check("R4 edge literal", x_out, 32'd2);
        run_step(32'h9ABC_DEF0, 32'h1234_5678, "R4 mid", 0);
    endtask

    task automatic t_saturate;
        run_step(32'h0000_5555, 32'h0000_5555, "R2 equal", 0);
        check("R2 literal", x_out, 32'hFFFF_FFFF);
        run_step(32'd0, 32'h4000_0000, "R3 zero", 0);
        check("R3 literal", x_out, 32'hFFFF_FFFF);
    endtask

    // A second start mid-run must be dropped; no stray done afterwards.
    task automatic t_busy_ignore;
        logic [W-1:0] held;
        int extra;
        int lat;
        @(negedge clk);
        x_in = 32'h0000_1000; p1 = 32'h0001_0000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            lat++;
        end
        x_in = 32'h0001_0000; p1 = 32'h0001_0000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat++;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        check("R8 latency unchanged", lat - 1, DIV_LAT);
        check("R8 value of first step", x_out, model(32'h0000_1000, 32'h0001_0000));
        held  = x_out;
        extra = 0;
        for (int i = 0; i < 2 * DIV_LAT; i++) begin
            @(negedge clk);
            if (done) extra++;
        end
        check("R8 no second done", extra, 0);
        check("R7 output held", x_out, held);
    endtask

    task automatic t_done_width;
        int width;
        @(negedge clk);
        x_in = 32'h0000_0777; p1 = 32'h0000_0777; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        width = 0;
        for (int i = 0; i < 6; i++) begin
            if (done) width++;
            @(negedge clk);
        end
        check("R7 done width", width, 1);
    endtask

    task automatic t_scramble;
        run_step(32'h0ABC_0000, 32'h7000_0001, "R9 low scrambled", 1);
        run_step(32'hE000_0001, 32'h2000_0000, "R9 high scrambled", 1);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst   = 1'b1;
        start = 1'b0;
        x_in  = '0;
        p1    = 32'd1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_lower();
        t_upper();
        t_saturate();
        t_busy_ignore();
        t_done_width();
        t_scramble();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule